// File: doc/BRIEF.md
# Quasi-Bidirectional Port Drive Controller

This block produces the per-pin drive enables for a port of quasi-bidirectional pins that has no direction register. Each pin has three enables: a strong pull-down, a weak current-source pull-up, and a short strong pull-up boost. All three follow an output latch that the serial-bus engine writes through a one-cycle strobe. A pin whose latch bit is 1 acts as an input, because an outside device can still pull it low against the weak pull-up. For the same reason, software must leave a pin's latch bit at 1 before it reads that pin.

When a 1 is written to a bit, the strong pull-up for that pin switches on, so a heavily loaded line gets a fast rising edge. The boost switches off at the next falling edge of the serial clock. The serial clock arrives asynchronously and passes through a synchronizer first. The pin levels come back through a synchronizer as well, and they form the port read value. So a latched-high pin that something outside holds low reads as 0.

Top module: `qbd_port_ctrl`

## Requirements
- R1: The cycle after synchronous reset, every latch bit is 1: wpu_en_o is all ones, pd_en_o is all zeros and spu_en_o is all zeros.
- R2: On the clock edge where wr_stb_i is high, every bit written as 0 gets pd_en_o=1, wpu_en_o=0 and spu_en_o=0 from that edge on.
- R3: On the clock edge where wr_stb_i is high, every bit written as 1 gets pd_en_o=0, wpu_en_o=1 and spu_en_o=1. This holds even if the bit was already 1.
- R4: After scl_i goes from 1 to 0, spu_en_o clears on the third rising clock edge (two synchronizer stages plus the drive register), and not before. Only the falling transition clears it. A clock that stays low does not clear a boost written later.
- R5: If a write and a detected SCL fall land on the same edge, the write wins: spu_en_o takes the written value.
- R6: In every cycle, no pin has spu_en_o and pd_en_o both at 1.
- R7: Without a write strobe, pd_en_o and wpu_en_o hold their values, and spu_en_o never goes from 0 to 1. A rising scl_i has no effect.
- R8: rd_data_o equals pin_i after two rising clock edges, whatever the latch holds. An external low on a latched-high pin reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock level, asynchronous |
| wr_stb_i | input | 1 | One-cycle latch write strobe |
| wr_data_i | input | WIDTH | Value written to the output latch |
| pin_i | input | WIDTH | Sensed pin levels, asynchronous |
| pd_en_o | output | WIDTH | Strong pull-down enable per pin |
| wpu_en_o | output | WIDTH | Weak pull-up enable per pin |
| spu_en_o | output | WIDTH | Strong pull-up boost enable per pin |
| rd_data_o | output | WIDTH | Synchronized pin levels (port read value) |

## Verification
The properties assume that wr_stb_i and wr_data_i change only away from the clock edge, and that reset is held for at least one edge before any property is judged. The stimulus drives every input on the falling clock edge and holds reset for several cycles at the start. It also keeps scl_i high whenever a boost must survive, so that each SCL fall the bench makes is one it chose. Every 8-bit write value is swept, each one followed by a fall. All 256 pin patterns are swept against a fixed latch to confirm that reads ignore the latch.

// File: rtl/qbd_pkg.sv
package qbd_pkg;
  // Drive enables of one pin, produced as one registered group.
  typedef struct packed {
    logic pd;   // strong pull-down
    logic wpu;  // weak current-source pull-up
    logic spu;  // strong pull-up boost
  } qbd_drive_t;

  localparam int unsigned QBD_DEF_WIDTH  = 8;
  localparam int unsigned QBD_DEF_STAGES = 2;
endpackage

// File: rtl/qbd_sync.sv
module qbd_sync #(
  parameter int unsigned WIDTH   = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= {WIDTH{RST_VAL}};
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/qbd_fall_det.sv
module qbd_fall_det (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic fall
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= lvl;
  end

  assign fall = prev_q & ~lvl;
endmodule

// File: rtl/qbd_pin_ctrl.sv
module qbd_pin_ctrl
  import qbd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_stb,
  input  logic       wr_bit,
  input  logic       scl_fall,
  output qbd_drive_t drv
);
  logic latch_q;
  logic boost_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= 1'b1;
      boost_q <= 1'b0;
    end else if (wr_stb) begin
      latch_q <= wr_bit;
      boost_q <= wr_bit;
    end else if (scl_fall) begin
      boost_q <= 1'b0;
    end
  end

  always_comb begin
    drv.pd  = ~latch_q;
    drv.wpu = latch_q;
    drv.spu = boost_q & latch_q;
  end
endmodule

// File: rtl/qbd_port_ctrl.sv
module qbd_port_ctrl
  import qbd_pkg::*;
#(
  parameter int unsigned WIDTH  = QBD_DEF_WIDTH,
  parameter int unsigned STAGES = QBD_DEF_STAGES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_i,
  input  logic             wr_stb_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] pd_en_o,
  output logic [WIDTH-1:0] wpu_en_o,
  output logic [WIDTH-1:0] spu_en_o,
  output logic [WIDTH-1:0] rd_data_o
);
  logic scl_s;
  logic scl_fall;

  qbd_sync #(.WIDTH(1), .STAGES(STAGES), .RST_VAL(1'b1)) u_scl_sync (
    .clk(clk), .rst(rst), .d(scl_i), .q(scl_s)
  );

  qbd_fall_det u_fall (
    .clk(clk), .rst(rst), .lvl(scl_s), .fall(scl_fall)
  );

  qbd_sync #(.WIDTH(WIDTH), .STAGES(STAGES), .RST_VAL(1'b1)) u_pin_sync (
    .clk(clk), .rst(rst), .d(pin_i), .q(rd_data_o)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    qbd_drive_t drv;
    qbd_pin_ctrl u_pin (
      .clk(clk), .rst(rst), .wr_stb(wr_stb_i), .wr_bit(wr_data_i[i]),
      .scl_fall(scl_fall), .drv(drv)
    );
    assign pd_en_o[i]  = drv.pd;
    assign wpu_en_o[i] = drv.wpu;
    assign spu_en_o[i] = drv.spu;
  end
endmodule

// File: rtl/qbd_port_ctrl_chk.sv
module qbd_port_ctrl_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_stb_i,
  input logic [WIDTH-1:0] wr_data_i,
  input logic [WIDTH-1:0] pd_en_o,
  input logic [WIDTH-1:0] wpu_en_o,
  input logic [WIDTH-1:0] spu_en_o
);
  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (pd_en_o == '0 && spu_en_o == '0 && wpu_en_o == '1)); // R1

  AST_WRITE_PD: assert property (@(posedge clk) disable iff (rst)
    wr_stb_i |=> (pd_en_o == ~$past(wr_data_i))); // R2

  AST_WRITE_BOOST: assert property (@(posedge clk) disable iff (rst)
    wr_stb_i |=> (spu_en_o == $past(wr_data_i))); // R3

  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (rst)
    (spu_en_o & pd_en_o) == '0); // R6

  AST_HOLD_PD: assert property (@(posedge clk) disable iff (rst)
    !wr_stb_i |=> $stable(pd_en_o)); // R7

  AST_HOLD_WPU: assert property (@(posedge clk) disable iff (rst)
    !wr_stb_i |=> $stable(wpu_en_o)); // R7

  AST_NO_BOOST_RISE: assert property (@(posedge clk) disable iff (rst)
    !wr_stb_i |=> ((spu_en_o & ~$past(spu_en_o)) == '0)); // R7
endmodule

bind qbd_port_ctrl qbd_port_ctrl_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .wr_stb_i(wr_stb_i), .wr_data_i(wr_data_i),
  .pd_en_o(pd_en_o), .wpu_en_o(wpu_en_o), .spu_en_o(spu_en_o)
);

// File: tb/qbd_port_ctrl_tb.sv
module qbd_port_ctrl_tb;
  localparam int unsigned W        = 8;
  localparam time         CLK_PER  = 10ns;
  localparam int unsigned WDOG_CYC = 100000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         scl = 1'b1;
  logic         wr_stb = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] pin = '1;
  logic [W-1:0] pd_en, wpu_en, spu_en, rd_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PER/2) clk = ~clk;

  qbd_port_ctrl #(.WIDTH(W), .STAGES(2)) u_dut (
    .clk(clk), .rst(rst), .scl_i(scl), .wr_stb_i(wr_stb), .wr_data_i(wr_data),
    .pin_i(pin), .pd_en_o(pd_en), .wpu_en_o(wpu_en), .spu_en_o(spu_en),
    .rd_data_o(rd_data)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_port(input logic [W-1:0] v);
    @(negedge clk);
    wr_stb  = 1'b1;
    wr_data = v;
    @(negedge clk);
    wr_stb  = 1'b0;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (WDOG_CYC) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    cycles(4);
    rst = 1'b0;
    cycles(1);
    // R1 reset state
    chk("R1 wpu", wpu_en, '1);
    chk("R1 pd", pd_en, '0);
    chk("R1 spu", spu_en, '0);

    // Sweep all values: R2 / R3 on write, R4 on SCL fall, R6 contention, R7 hold
    for (int v = 0; v < 256; v++) begin
      logic [W-1:0] val;
      val = W'(v);
      write_port(val);
      chk("R2 pd", pd_en, ~val);
      chk("R3 wpu", wpu_en, val);
      chk("R3 spu", spu_en, val);
      chk("R6 overlap", spu_en & pd_en, '0);
      @(negedge clk); scl = 1'b0;
      cycles(2);
      chk("R4 boost before clear", spu_en, val);
      cycles(1);
      chk("R4 boost cleared", spu_en, '0);
      chk("R7 pd hold", pd_en, ~val);
      chk("R7 wpu hold", wpu_en, val);
      @(negedge clk); scl = 1'b1;
      cycles(3);
    end

    // R3 rewrite of an already-1 bit restarts the boost
    write_port(8'hFF);
    @(negedge clk); scl = 1'b0; cycles(3);
    write_port(8'hFF);
    chk("R3 rewrite boost", spu_en, 8'hFF);
    cycles(3);
    chk("R4 low level does not clear", spu_en, 8'hFF);
    @(negedge clk); scl = 1'b1; cycles(4);
    chk("R7 SCL rise no effect", spu_en, 8'hFF);
    chk("R7 SCL rise pd", pd_en, 8'h00);

    // R5 write on the same edge as the detected fall
    write_port(8'h0F);
    @(negedge clk); scl = 1'b0;
    @(negedge clk);
    @(negedge clk);
    wr_stb = 1'b1; wr_data = 8'hF0;
    @(negedge clk);
    wr_stb = 1'b0;
    chk("R5 write wins", spu_en, 8'hF0);
    chk("R5 pd", pd_en, 8'h0F);
    cycles(2);
    chk("R4 no second clear", spu_en, 8'hF0);
    @(negedge clk); scl = 1'b1; cycles(3);

    // R8 read value is the pin level regardless of latch
    write_port(8'hFF);
    for (int p = 0; p < 256; p++) begin
      @(negedge clk); pin = W'(p);
      cycles(2);
      chk("R8 read", rd_data, W'(p));
    end
    write_port(8'h00);
    @(negedge clk); pin = 8'hA5; cycles(2);
    chk("R8 read ignores latch", rd_data, 8'hA5);

    // R1 reset again mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 re-reset wpu", wpu_en, '1);
    chk("R1 re-reset spu", spu_en, '0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule